// File: doc/BRIEF.md
# Nibble-Wide Swap Register Port

This block gives a host processor on an 8-bit, 6502-style bus access to a bank of byte-wide registers. It sees only four data lines and the read/write line, and it does not decode the address bus. The host arms the port by writing a separate bank latch with its top bit set. The host then runs a fixed sequence of four absolute-address instructions, all to the same address: store Y, store X, load Y, load X. The port follows that sequence one bus cycle at a time, using a cycle-valid strobe. While it follows the sequence it picks up the register index from the operand bytes of the store X instruction as they pass over the data bus.

Each armed pass is a swap. The stored byte, split into a low nibble (store Y) and a high nibble (store X), replaces the selected register. During the data cycles of the two loads, the port drives the byte the register held before the write, low nibble first and then high nibble. A status pair reports whether a pass is running or has finished. The host closes the pass by writing the bank latch with the top bit clear. Writing that clear before the high data nibble arrives cancels the pass, and no register is written.

Top module: `nib_swap_port`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `nib_oe_o` are low, `bank_o` is 0x00, and every register holds 0x00.
- R2: A strobed bank write (`cyc_vld_i` and `bank_wr_i` high) loads `bank_o` with `bank_d_i`. If bit 7 of that byte is set while the port is idle, `busy_o` is high from the next cycle.
- R3: After arming, every strobed cycle with `rw_i` high is skipped until the first strobed cycle with `rw_i` low. The nibble on `nib_i` in that cycle becomes the low write nibble (bits 3:0).
- R4: The next four strobed cycles form the store X instruction. Cycle 2 supplies index bits 3:0, cycle 3 supplies index bits 7:4, and cycle 4 supplies the high write nibble (bits 7:4). Cycle 1 is ignored.
- R5: Each load instruction is four strobed cycles. In the 4th cycle of the first load, `nib_o` carries bits 3:0 of the register's old value. In the 4th cycle of the second load, it carries bits 7:4.
- R6: `nib_oe_o` is high only in those two load data cycles, and it drops after the strobe that ends each of them.
- R7: Completing the store X data cycle writes the new byte to the indexed register. The value returned by the loads is always the one held before that write.
- R8: After the second load's data cycle, `done_o` is high and `busy_o` is low. They stay that way until a strobed bank write with bit 7 clear returns the port to idle (both low).
- R9: A strobed bank write with bit 7 clear, made before the store X data cycle, returns the port to idle at once and leaves every register unchanged.
- R10: Clock cycles with `cyc_vld_i` low neither advance the sequence nor capture data, whatever `rw_i`, `nib_i`, `bank_wr_i` and `bank_d_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_vld_i | input | 1 | One-clock strobe marking the sample point of a bus cycle |
| rw_i | input | 1 | Bus direction, high = read |
| nib_i | input | 4 | Data lines D3..D0 as sampled |
| bank_wr_i | input | 1 | Bank latch write select for the current bus cycle |
| bank_d_i | input | 8 | Full data byte for the bank latch |
| bank_o | output | 8 | Bank latch contents, bit 7 = arm |
| nib_o | output | 4 | Nibble driven back onto D3..D0 |
| nib_oe_o | output | 1 | Output enable for `nib_o` |
| busy_o | output | 1 | A swap pass is in progress |
| done_o | output | 1 | Swap pass finished, waiting for disarm |

## Verification
The assertions assume three things about the inputs. `rw_i`, `nib_i`, `bank_wr_i` and `bank_d_i` are valid on every clock where `cyc_vld_i` is high. A bank write is only ever qualified by that strobe. An armed host issues exactly the four-instruction sequence, all to one address, or cancels it with a disarming bank write. The stimulus drives legal sequences on strobed cycles only, with varying numbers of skipped read cycles before the first store data cycle. On every unstrobed clock it puts random values on all inputs, so that any sampling outside the strobe would corrupt the results.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_STX,
    ST_LDY,
    ST_LDX,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/nsp_trig_latch.sv
module nsp_trig_latch #(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] d_i,
  output logic [BANK_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= d_i;
  end
endmodule

// File: rtl/nsp_regfile.sv
module nsp_regfile #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned DAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DAT_W-1:0] wdata_i,
  output logic [DAT_W-1:0] old_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] mem_q [DEPTH];

  // old value snapshotted in the same edge as the write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      old_o <= '0;
    end else if (we_i) begin
      old_o        <= mem_q[idx_i];
      mem_q[idx_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/nsp_seq.sv
module nsp_seq
  import nsp_pkg::*;
#(
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned STEPS    = 4,
  parameter int unsigned BANK_W   = 8,
  parameter int unsigned TRIG_BIT = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cyc_vld_i,
  input  logic                 rw_i,
  input  logic [NIB_W-1:0]     nib_i,
  input  logic                 bank_wr_i,
  input  logic [BANK_W-1:0]    bank_d_i,
  output seq_st_e              st_o,
  output logic                 commit_o,
  output logic [2*NIB_W-1:0]   idx_o,
  output logic [2*NIB_W-1:0]   wdata_o,
  output logic                 drive_o,
  output logic                 sel_hi_o
);
  localparam int unsigned CNT_W = $clog2(STEPS);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(STEPS - 1);
  localparam logic [CNT_W-1:0] ADR_LO = CNT_W'(1);
  localparam logic [CNT_W-1:0] ADR_HI = CNT_W'(2);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NIB_W-1:0] dlo_q, alo_q, ahi_q;
  logic             ev_arm, ev_clr, step;

  assign ev_arm = cyc_vld_i && bank_wr_i &&  bank_d_i[TRIG_BIT];
  assign ev_clr = cyc_vld_i && bank_wr_i && !bank_d_i[TRIG_BIT];
  assign step   = cyc_vld_i && !ev_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      dlo_q <= '0;
      alo_q <= '0;
      ahi_q <= '0;
    end else if (ev_clr) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (step) begin
      unique case (st_q)
        ST_IDLE: if (ev_arm) st_q <= ST_SYNC;
        ST_SYNC: if (!rw_i) begin
          dlo_q <= nib_i;
          cnt_q <= '0;
          st_q  <= ST_STX;
        end
        ST_STX, ST_LDY, ST_LDX: begin
          if (st_q == ST_STX && cnt_q == ADR_LO) alo_q <= nib_i;
          if (st_q == ST_STX && cnt_q == ADR_HI) ahi_q <= nib_i;
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            st_q  <= (st_q == ST_STX) ? ST_LDY :
                     (st_q == ST_LDY) ? ST_LDX : ST_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DONE: ;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o     = st_q;
  assign commit_o = step && st_q == ST_STX && cnt_q == LAST;
  assign idx_o    = {ahi_q, alo_q};
  assign wdata_o  = {nib_i, dlo_q};
  assign drive_o  = (st_q == ST_LDY || st_q == ST_LDX) && cnt_q == LAST;
  assign sel_hi_o = st_q == ST_LDX;

  // index nibbles must be in place before the commit edge
  p_idx_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $stable(ahi_q) && $stable(alo_q));
endmodule

// File: rtl/nib_swap_port.sv
module nib_swap_port
  import nsp_pkg::*;
#(
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned BANK_W   = 8,
  parameter int unsigned TRIG_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_vld_i,
  input  logic              rw_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              bank_wr_i,
  input  logic [BANK_W-1:0] bank_d_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [NIB_W-1:0]  nib_o,
  output logic              nib_oe_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned IDX_W = 2 * NIB_W;
  localparam int unsigned DAT_W = 2 * NIB_W;

  seq_st_e          st;
  logic             commit, drive, sel_hi;
  logic [IDX_W-1:0] idx;
  logic [DAT_W-1:0] wdata, old;

  nsp_trig_latch #(.BANK_W(BANK_W)) i_trig (
    .clk_i, .rst_ni,
    .wr_i (bank_wr_i && cyc_vld_i),
    .d_i  (bank_d_i),
    .q_o  (bank_o)
  );

  nsp_seq #(.NIB_W(NIB_W), .STEPS(4), .BANK_W(BANK_W), .TRIG_BIT(TRIG_BIT)) i_seq (
    .clk_i, .rst_ni, .cyc_vld_i, .rw_i, .nib_i, .bank_wr_i, .bank_d_i,
    .st_o     (st),
    .commit_o (commit),
    .idx_o    (idx),
    .wdata_o  (wdata),
    .drive_o  (drive),
    .sel_hi_o (sel_hi)
  );

  nsp_regfile #(.IDX_W(IDX_W), .DAT_W(DAT_W)) i_rf (
    .clk_i, .rst_ni,
    .we_i    (commit),
    .idx_i   (idx),
    .wdata_i (wdata),
    .old_o   (old)
  );

  assign nib_o    = sel_hi ? old[DAT_W-1:NIB_W] : old[NIB_W-1:0];
  assign nib_oe_o = drive;
  assign busy_o   = st != ST_IDLE && st != ST_DONE;
  assign done_o   = st == ST_DONE;

  p_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o && cyc_vld_i && bank_wr_i && bank_d_i[TRIG_BIT]) |=> busy_o);

  p_oe_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_oe_o |-> busy_o && !done_o);

  p_oe_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_oe_o && cyc_vld_i) |=> !nib_oe_o);

  p_commit_armed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> bank_o[TRIG_BIT]);

  p_clear_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_vld_i && bank_wr_i && !bank_d_i[TRIG_BIT]) |=> !busy_o && !done_o);

  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(cyc_vld_i && bank_wr_i && !bank_d_i[TRIG_BIT])) |=> done_o);

  p_no_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_vld_i |=> $stable(busy_o) && $stable(done_o) && $stable(bank_o));
endmodule

// File: tb/test_nib_swap_port.sv
module test_nib_swap_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_vld = 1'b0;
  logic       rw = 1'b1;
  logic [3:0] nib_in = '0;
  logic       bank_wr = 1'b0;
  logic [7:0] bank_d = '0;
  logic [7:0] bank_q;
  logic [3:0] nib_out;
  logic       nib_oe, busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [7:0] model [256];

  always #4 clk = ~clk;

  nib_swap_port i_nib_swap_port (
    .clk_i (clk), .rst_ni (rst_n), .cyc_vld_i (cyc_vld), .rw_i (rw),
    .nib_i (nib_in), .bank_wr_i (bank_wr), .bank_d_i (bank_d),
    .bank_o (bank_q), .nib_o (nib_out), .nib_oe_o (nib_oe),
    .busy_o (busy), .done_o (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle: strobed clock, then an unstrobed clock with garbage inputs
  task automatic bcyc(input logic bw, input logic [7:0] bd, input logic r,
                      input logic [3:0] n, input logic exp_oe, input logic [3:0] exp_n,
                      input string req);
    @(negedge clk);
    cyc_vld = 1'b1; bank_wr = bw; bank_d = bd; rw = r; nib_in = n;
    #1;
    chk("R6 oe", int'(nib_oe), int'(exp_oe));
    if (exp_oe) chk(req, int'(nib_out), int'(exp_n));
    @(negedge clk);
    cyc_vld = 1'b0;                       // R10 garbage on unstrobed clock
    bank_wr = 1'($urandom); bank_d = 8'($urandom);
    rw = 1'($urandom); nib_in = 4'($urandom);
  endtask

  task automatic rd_cyc(input logic [3:0] n);
    bcyc(1'b0, 8'h00, 1'b1, n, 1'b0, 4'h0, "");
  endtask

  task automatic arm(input logic [7:0] bank);
    bcyc(1'b1, bank | 8'h80, 1'b0, 4'h0, 1'b0, 4'h0, "");
    chk("R2 bank", int'(bank_q), int'(bank | 8'h80));
    chk("R2 busy", int'(busy), 1);
  endtask

  task automatic swap(input int lead, input logic [7:0] idx, input logic [7:0] val,
                      input logic [7:0] bank);
    logic [7:0] old;
    old = model[idx];
    arm(bank);
    for (int i = 0; i < lead; i++) rd_cyc(4'($urandom));              // R3 skipped
    bcyc(1'b0, 8'h00, 1'b0, val[3:0], 1'b0, 4'h0, "");               // store Y data
    rd_cyc(4'hE); rd_cyc(idx[3:0]); rd_cyc(idx[7:4]);                 // R4 operands
    bcyc(1'b0, 8'h00, 1'b0, val[7:4], 1'b0, 4'h0, "");               // store X data
    model[idx] = val;
    rd_cyc(4'hC); rd_cyc(idx[3:0]); rd_cyc(idx[7:4]);
    bcyc(1'b0, 8'h00, 1'b1, 4'($urandom), 1'b1, old[3:0], "R5 R7 low nibble");
    chk("R8 busy mid", int'(busy), 1);
    rd_cyc(4'hE); rd_cyc(idx[3:0]); rd_cyc(idx[7:4]);
    bcyc(1'b0, 8'h00, 1'b1, 4'($urandom), 1'b1, old[7:4], "R5 R7 high nibble");
    chk("R8 done", int'(done), 1);
    chk("R8 busy", int'(busy), 0);
    rd_cyc(4'h9); rd_cyc(4'hF);
    rd_cyc(4'hD); rd_cyc(4'h0); rd_cyc(4'h0);
    chk("R8 done hold", int'(done), 1);
    bcyc(1'b1, bank & 8'h7F, 1'b0, 4'h0, 1'b0, 4'h0, "");
    chk("R8 idle done", int'(done), 0);
    chk("R8 idle busy", int'(busy), 0);
    chk("R2 bank clr", int'(bank_q), int'(bank & 8'h7F));
  endtask

  task automatic abort_swap(input logic [7:0] idx, input logic [7:0] val);
    arm(8'h03);
    rd_cyc(4'h8); rd_cyc(idx[3:0]); rd_cyc(idx[7:4]);
    bcyc(1'b0, 8'h00, 1'b0, val[3:0], 1'b0, 4'h0, "");
    rd_cyc(4'hE); rd_cyc(idx[3:0]); rd_cyc(idx[7:4]);
    bcyc(1'b1, 8'h03, 1'b0, val[7:4], 1'b0, 4'h0, "");               // R9 clear in data slot
    chk("R9 busy", int'(busy), 0);
    chk("R9 done", int'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 oe", int'(nib_oe), 0);
    chk("R1 bank", int'(bank_q), 0);
    // R10: unstrobed junk must not arm anything
    repeat (5) begin
      @(negedge clk);
      bank_wr = 1'b1; bank_d = 8'hFF; rw = 1'b0; nib_in = 4'h5;
    end
    @(negedge clk);
    bank_wr = 1'b0;
    chk("R10 no arm", int'(busy), 0);
    chk("R10 bank", int'(bank_q), 0);

    swap(3, 8'h53, 8'hA7, 8'h05);   // R1 old value zero, R7
    swap(3, 8'h53, 8'h1C, 8'h05);   // R7 returns A7
    swap(0, 8'h31, 8'h6E, 8'h02);   // R3 no leading cycles
    swap(1, 8'h35, 8'h42, 8'h00);   // R4 index nibbles distinct
    swap(2, 8'hFF, 8'h99, 8'h11);
    swap(3, 8'h00, 8'h5A, 8'h7F);
    abort_swap(8'h35, 8'hDD);       // R9
    swap(3, 8'h35, 8'h00, 8'h01);   // R9 must still return 42
    swap(3, 8'h53, 8'hF0, 8'h05);   // R7 returns 1C
    swap(2, 8'hFF, 8'h01, 8'h05);   // returns 99
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule